// File: doc/BRIEF.md
# Shunt Current Fault Delay Protector

This block guards a battery pack against excessive current, working on a signed sense-voltage sample stream that has already been digitized from the current shunt. It runs four independent checks in parallel. One catches sustained overcurrent while discharging. One catches a short circuit while charging. Two catch a short circuit while discharging, at separately programmed levels. Each check compares the sample against a threshold built from a small code, and it declares a fault only when the condition has held without a break for the programmed delay. The delay is counted in ticks of a slow timebase.

A latched fault stays set until a synchronous clear pulse arrives. While it is set, the block removes the enable from the protection FET on the affected side: the charge fault turns the charge FET off, and any discharge fault turns the discharge FET off. One range bit doubles every threshold. Another bit doubles the delay step of both short-circuit-discharge checks.

Top module: `cur_fault_guard`

## Requirements
- R1: After reset, all four fault flags are 0 and both `chg_en` and `dsg_en` are 1.
- R2: Discharge overcurrent trips when `sample` < −(3 + `ocd_thr`)·OCD_LSB·k, where k = 2 if `sense_x2` = 1 and k = 1 otherwise. A sample equal to the threshold does not trip. The condition must hold for 262 + 524·`ocd_dly` ticks.
- R3: Charge short circuit trips when `sample` > +(2 + `scc_thr`)·SC_LSB·k, held for 16·`scc_dly` ticks. A delay code of 0 latches on the first clock the condition holds.
- R4: The first discharge short circuit trips when `sample` < −(2 + `scd1_thr`)·SC_LSB·k, held for `scd1_dly`·16 ticks, or `scd1_dly`·32 ticks when `scd_x2` = 1.
- R5: The second discharge short circuit trips when `sample` < −(2 + `scd2_thr`)·SC_LSB·k, held for `scd2_dly`·8 ticks, or `scd2_dly`·16 ticks when `scd_x2` = 1.
- R6: If a check's condition goes false on any clock before its delay expires, that check's tick count restarts from zero.
- R7: A fault flag stays set after its condition goes away. A `clr` pulse clears all flags and all tick counts on the next clock.
- R8: `chg_en` is low while the charge fault is set. `dsg_en` is low while any discharge fault is set. An enable returns high only after `clr`.
- R9: `fault` bit positions are: bit 0 discharge overcurrent, bit 1 charge short circuit, bit 2 first discharge short circuit, bit 3 second discharge short circuit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock timebase pulse (262.144 kHz nominal) |
| clr | input | 1 | Synchronous clear of flags and counters |
| sample | input | SAMPLE_W | Signed shunt voltage sample |
| sense_x2 | input | 1 | Doubles all thresholds |
| scd_x2 | input | 1 | Doubles the delay step of both discharge short-circuit checks |
| ocd_thr | input | 4 | Overcurrent threshold code |
| ocd_dly | input | 4 | Overcurrent delay code |
| scc_thr | input | 3 | Charge short-circuit threshold code |
| scc_dly | input | 4 | Charge short-circuit delay code |
| scd1_thr | input | 3 | First discharge short-circuit threshold code |
| scd1_dly | input | 4 | First discharge short-circuit delay code |
| scd2_thr | input | 3 | Second discharge short-circuit threshold code |
| scd2_dly | input | 4 | Second discharge short-circuit delay code |
| fault | output | 4 | Latched fault flags (order per R9) |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |

## Verification
The assertions assume that `sample` and the configuration codes change only between clock edges. They also assume that `tick` is a single-clock pulse. The bench drives every input on the falling edge and spaces ticks four clocks apart. In each scenario, the thresholds of the checks not under test are set out of reach, and the overcurrent delay is left at its longest. This keeps the shared sample from tripping a second check before the bench issues its clear.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_OCD  = 0;
    localparam int CH_SCC  = 1;
    localparam int CH_SCD1 = 2;
    localparam int CH_SCD2 = 3;
    localparam int CODE_W  = 4;
endpackage

// File: rtl/cfd_trip_cmp.sv
module cfd_trip_cmp #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 4,
    parameter int BASE     = 2,
    parameter int STEP_LSB = 111,
    parameter bit POSITIVE = 1'b0
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CODE_W-1:0]   code,
    input  logic                range_x2,
    output logic                trip
);
    logic [SAMPLE_W-1:0] steps;
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] mag_sc;
    logic signed [SAMPLE_W:0] thr;
    logic signed [SAMPLE_W:0] s_ext;

    always_comb begin
        steps  = SAMPLE_W'(BASE) + SAMPLE_W'(code);
        mag    = steps * SAMPLE_W'(STEP_LSB);
        mag_sc = range_x2 ? {mag[SAMPLE_W-2:0], 1'b0} : mag;
        thr    = $signed({1'b0, mag_sc});
        s_ext  = $signed({sample[SAMPLE_W-1], sample});
    end

    generate
        if (POSITIVE) begin : g_pos
            assign trip = (s_ext > thr);
        end else begin : g_neg
            assign trip = (s_ext < -thr);
        end
    endgenerate
endmodule

// File: rtl/cfd_delay_timer.sv
module cfd_delay_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             trip,
    input  logic [CNT_W-1:0] limit,
    output logic             fault
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else begin
            if (!trip) begin
                st_d.cnt = '0;
            end else if (tick && (st_q.cnt < limit)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (trip && (st_q.cnt >= limit)) begin
                st_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;
endmodule

// File: rtl/cur_fault_guard.sv
module cur_fault_guard
    import cfd_pkg::*;
#(
    parameter int SAMPLE_W       = 16,
    parameter int OCD_LSB        = 28,
    parameter int SC_LSB         = 111,
    parameter int OCD_BASE_TICKS = 262,
    parameter int OCD_STEP_TICKS = 524,
    parameter int SC_STEP_TICKS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                clr,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sense_x2,
    input  logic                scd_x2,
    input  logic [3:0]          ocd_thr,
    input  logic [3:0]          ocd_dly,
    input  logic [2:0]          scc_thr,
    input  logic [3:0]          scc_dly,
    input  logic [2:0]          scd1_thr,
    input  logic [3:0]          scd1_dly,
    input  logic [2:0]          scd2_thr,
    input  logic [3:0]          scd2_dly,
    output logic [3:0]          fault,
    output logic                chg_en,
    output logic                dsg_en
);
    localparam int DLY_MAX   = (1 << CODE_W) - 1;
    localparam int OCD_MAX   = OCD_BASE_TICKS + DLY_MAX * OCD_STEP_TICKS;
    localparam int SCD_MAX   = DLY_MAX * 2 * SC_STEP_TICKS;
    localparam int LIMIT_MAX = (OCD_MAX > SCD_MAX) ? OCD_MAX : SCD_MAX;
    localparam int CNT_W     = $clog2(LIMIT_MAX + 1);
    localparam int SCD2_STEP = SC_STEP_TICKS / 2;

    logic [CODE_W-1:0] thr_code [NUM_CH];
    logic [CNT_W-1:0]  lim      [NUM_CH];
    logic [NUM_CH-1:0] trip_vec;

    always_comb begin
        thr_code[CH_OCD]  = ocd_thr;
        thr_code[CH_SCC]  = {1'b0, scc_thr};
        thr_code[CH_SCD1] = {1'b0, scd1_thr};
        thr_code[CH_SCD2] = {1'b0, scd2_thr};

        lim[CH_OCD] = CNT_W'(OCD_BASE_TICKS) + CNT_W'(ocd_dly) * CNT_W'(OCD_STEP_TICKS);
        lim[CH_SCC] = CNT_W'(scc_dly) * CNT_W'(SC_STEP_TICKS);
        lim[CH_SCD1] = scd_x2 ? CNT_W'(scd1_dly) * CNT_W'(2 * SC_STEP_TICKS)
                              : CNT_W'(scd1_dly) * CNT_W'(SC_STEP_TICKS);
        lim[CH_SCD2] = scd_x2 ? CNT_W'(scd2_dly) * CNT_W'(2 * SCD2_STEP)
                              : CNT_W'(scd2_dly) * CNT_W'(SCD2_STEP);
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            cfd_trip_cmp #(
                .SAMPLE_W (SAMPLE_W),
                .CODE_W   (CODE_W),
                .BASE     ((g == CH_OCD) ? 3 : 2),
                .STEP_LSB ((g == CH_OCD) ? OCD_LSB : SC_LSB),
                .POSITIVE ((g == CH_SCC) ? 1'b1 : 1'b0)
            ) u_cmp (
                .sample   (sample),
                .code     (thr_code[g]),
                .range_x2 (sense_x2),
                .trip     (trip_vec[g])
            );

            cfd_delay_timer #(
                .CNT_W (CNT_W)
            ) u_tmr (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .tick  (tick),
                .trip  (trip_vec[g]),
                .limit (lim[g]),
                .fault (fault[g])
            );
        end
    endgenerate

    assign chg_en = ~fault[CH_SCC];
    assign dsg_en = ~(fault[CH_OCD] | fault[CH_SCD1] | fault[CH_SCD2]);
endmodule

// File: rtl/cfd_guard_chk.sv
module cfd_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic [3:0] trip,
    input logic [3:0] fault,
    input logic       chg_en,
    input logic       dsg_en
);
    generate
        for (genvar k = 0; k < 4; k++) begin : g_k
            // R6: a flag can only rise after a clock where its condition held
            p_rise_needs_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fault[k]) |-> $past(trip[k]));
            // R7: a set flag holds until clear
            p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (fault[k] && !clr) |=> fault[k]);
        end
    endgenerate

    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fault == 4'b0000));

    p_chg_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en) |-> $past(clr));

    p_dsg_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_en) |-> $past(clr));
endmodule

bind cur_fault_guard cfd_guard_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .trip   (trip_vec),
    .fault  (fault),
    .chg_en (chg_en),
    .dsg_en (dsg_en)
);

// File: tb/test_cur_fault_guard.sv
module test_cur_fault_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] sample = '0;
    logic        sense_x2 = 1'b0;
    logic        scd_x2 = 1'b0;
    logic [3:0]  ocd_thr = '0;
    logic [3:0]  ocd_dly = 4'd15;
    logic [2:0]  scc_thr = 3'd7;
    logic [3:0]  scc_dly = '0;
    logic [2:0]  scd1_thr = 3'd7;
    logic [3:0]  scd1_dly = '0;
    logic [2:0]  scd2_thr = 3'd7;
    logic [3:0]  scd2_dly = '0;
    logic [3:0]  fault;
    logic        chg_en;
    logic        dsg_en;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cur_fault_guard i_cur_fault_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .sample(sample),
        .sense_x2(sense_x2), .scd_x2(scd_x2),
        .ocd_thr(ocd_thr), .ocd_dly(ocd_dly),
        .scc_thr(scc_thr), .scc_dly(scc_dly),
        .scd1_thr(scd1_thr), .scd1_dly(scd1_dly),
        .scd2_thr(scd2_thr), .scd2_dly(scd2_dly),
        .fault(fault), .chg_en(chg_en), .dsg_en(dsg_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_clear();
        @(negedge clk) begin sample = '0; clr = 1'b1; end
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fault", fault, 0);
        chk("R1 chg_en", chg_en, 1);
        chk("R1 dsg_en", dsg_en, 1);
    endtask

    // R2: overcurrent, x2 threshold 3*28*2=168, delay 262 ticks
    task automatic t_ocd();
        @(negedge clk) begin sense_x2 = 1'b1; ocd_thr = 0; ocd_dly = 0; sample = -16'sd169; end
        ticks(261);
        chk("R2 before delay", fault, 0);
        ticks(1);
        chk("R2 after delay R9 bit0", fault, 1);
        chk("R8 dsg_en off", dsg_en, 0);
        chk("R8 chg_en stays", chg_en, 1);
        @(negedge clk) sample = '0;
        ticks(10);
        chk("R7 sticky", fault, 1);
        chk("R8 dsg_en held", dsg_en, 0);
        do_clear();
        chk("R7 cleared", fault, 0);
        chk("R8 dsg_en back", dsg_en, 1);
        @(negedge clk) sample = -16'sd168;
        ticks(300);
        chk("R2 equal no trip", fault, 0);
        @(negedge clk) begin sense_x2 = 1'b0; sample = -16'sd85; end
        ticks(262);
        chk("R2 x1 threshold trips", fault, 1);
        do_clear();
        @(negedge clk) ocd_dly = 4'd15;
    endtask

    // R3: charge short, x1 threshold (2+1)*111=333, delay 3*16=48
    task automatic t_scc();
        @(negedge clk) begin sense_x2 = 1'b0; scc_thr = 1; scc_dly = 3; sample = 16'sd333; end
        ticks(60);
        chk("R3 equal no trip", fault, 0);
        @(negedge clk) sample = 16'sd334;
        ticks(47);
        chk("R3 before delay", fault, 0);
        ticks(1);
        chk("R3 after delay R9 bit1", fault, 2);
        chk("R8 chg_en off", chg_en, 0);
        chk("R8 dsg_en stays", dsg_en, 1);
        do_clear();
        chk("R8 chg_en back", chg_en, 1);
        @(negedge clk) begin scc_dly = 0; sample = 16'sd334; end
        @(negedge clk);
        chk("R3 zero delay", fault, 2);
        do_clear();
        @(negedge clk) scc_thr = 3'd7;
    endtask

    // R4: first discharge short, x2 threshold 2*111*2=444
    task automatic t_scd1();
        @(negedge clk) begin sense_x2 = 1'b1; scd1_thr = 0; scd1_dly = 2; scd_x2 = 1'b1; sample = -16'sd445; end
        ticks(63);
        chk("R4 x2 before delay", fault, 0);
        ticks(1);
        chk("R4 x2 after delay R9 bit2", fault, 4);
        chk("R8 dsg_en off scd1", dsg_en, 0);
        do_clear();
        @(negedge clk) begin scd_x2 = 1'b0; sample = -16'sd445; end
        ticks(31);
        chk("R4 x1 before delay", fault, 0);
        ticks(1);
        chk("R4 x1 after delay", fault, 4);
        do_clear();
        @(negedge clk) scd1_thr = 3'd7;
    endtask

    // R5: second discharge short, threshold 444
    task automatic t_scd2();
        @(negedge clk) begin sense_x2 = 1'b1; scd2_thr = 0; scd2_dly = 4; scd_x2 = 1'b0; sample = -16'sd445; end
        ticks(31);
        chk("R5 x1 before delay", fault, 0);
        ticks(1);
        chk("R5 x1 after delay R9 bit3", fault, 8);
        do_clear();
        @(negedge clk) begin scd_x2 = 1'b1; sample = -16'sd445; end
        ticks(63);
        chk("R5 x2 before delay", fault, 0);
        ticks(1);
        chk("R5 x2 after delay", fault, 8);
        chk("R8 dsg_en off scd2", dsg_en, 0);
        do_clear();
        @(negedge clk) scd2_thr = 3'd7;
    endtask

    // R6: a one-clock lapse restarts the count (SCC, 64 ticks)
    task automatic t_lapse();
        @(negedge clk) begin sense_x2 = 1'b0; scc_thr = 1; scc_dly = 4; sample = 16'sd334; end
        ticks(40);
        @(negedge clk) sample = '0;
        @(negedge clk) sample = 16'sd334;
        ticks(63);
        chk("R6 restarted count", fault, 0);
        ticks(1);
        chk("R6 full delay after lapse", fault, 2);
        do_clear();
        @(negedge clk) scc_thr = 3'd7;
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ocd();
        t_scc();
        t_scd1();
        t_scd2();
        t_lapse();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule